// File: doc/BRIEF.md
# Capability Segment Base Calculator

This block takes a tagged capability (a 64-bit address plus the compressed size exponent, compressed length and finger fields) and rebuilds, from those fields alone, the start address of the segment that the address points into. It also reports the segment size in words. A garbage collector support path uses it to find an object's base from any pointer into the object. No stored base is read from anywhere.

The size decode works like this. An exponent code of all ones (63) marks a small segment of `L'+1` single words, so the block shift is 0 and the last block index is `L'`. Any other exponent code `E` gives a segment of `L'+17` blocks of `2^E` words, so the block shift is `E` and the last block index is `L'+16`.

The finger names the block that holds the address. The offset of the address from the base is the finger shifted up by the block shift, ORed with the address bits below the block shift. The base is the address minus that offset.

A request is presented with a one-cycle strobe. The result appears one clock later together with a one-cycle result strobe. The outputs hold their values until the next request.

Top module: `capSegBase`

## Requirements
- R1: `resValid` is high in the cycle after each cycle in which `reqStrobe` is high, and low in every other cycle.
- R2: While `rstN` is low, `resValid`, `resOk`, `segBase` and `segSize` are all zero.
- R3: With `capExp` = 63 (small form) and the request accepted, `segSize` is `capMant+1` and `segBase` is `capAddr - capFinger`.
- R4: With `capExp` < 63 (large form) and the request accepted, `segSize` is `(capMant+17) << capExp` words.
- R5: With the request accepted, `segBase` equals `capAddr` with its low `B` bits cleared, minus `capFinger << B`, modulo 2^64. `B` is 0 in the small form and `capExp` in the large form.
- R6: A request is rejected when the finger exceeds the last block index. That index is `capMant` in the small form and `capMant+16` in the large form. A rejected request gives `resOk` = 0, `segBase` = 0 and `segSize` = 0.
- R7: A request with `capTag` low is rejected in the same way: `resOk` = 0, `segBase` = 0 and `segSize` = 0.
- R8: When the true size does not fit in 64 bits, `segSize` saturates to all ones.
- R9: In a cycle without `reqStrobe`, `resOk`, `segBase` and `segSize` keep their values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqStrobe | input | 1 | Request strobe, one cycle per request |
| capTag | input | 1 | Capability tag bit |
| capAddr | input | 64 | Address held in the capability |
| capExp | input | 6 | Compressed size exponent; 63 selects the small form |
| capMant | input | 4 | Compressed length |
| capFinger | input | 5 | Index of the block that holds the address |
| resValid | output | 1 | Result strobe, one cycle after the request |
| resOk | output | 1 | Capability accepted (tag set and finger in range) |
| segBase | output | 64 | Segment base address, or zero if rejected |
| segSize | output | 64 | Segment size in words, saturated, or zero if rejected |

## Verification
Size saturation and finger rejection can both apply to the same request. For example, exponent 62 with length 0 overflows the size, and finger 20 is beyond last block 16. The bench issues exactly that request, and the rejection must win: both outputs are zero and `resOk` is low.

A cleared tag combined with an out-of-range finger is provoked the same way. So are back-to-back strobes, which load a new result in the cycle the previous one is shown.

A behavioural model computes every expectation with 128-bit arithmetic. It is compared with the outputs every cycle, over directed corners and a stream of random requests.

// File: rtl/capBasePkg.sv
package capBasePkg;
  typedef struct packed {
    logic capture;
    logic accept;
  } capCtrlT;
endpackage

// File: rtl/capSizeDecode.sv
module capSizeDecode #(
  parameter int EXP_W  = 6,
  parameter int MANT_W = 4
) (
  input  logic [EXP_W-1:0]  expCode,
  input  logic [MANT_W-1:0] mantCode,
  output logic [EXP_W-1:0]  blockShift,
  output logic [MANT_W:0]   lastBlock,
  output logic [MANT_W+1:0] blockCount
);
  logic smallForm;

  always_comb begin
    smallForm  = &expCode;
    blockShift = smallForm ? '0 : expCode;
    lastBlock  = {~smallForm, mantCode};
    blockCount = {1'b0, lastBlock} + 1'b1;
  end
endmodule

// File: rtl/capBaseDatapath.sv
module capBaseDatapath
  import capBasePkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int EXP_W  = 6,
  parameter int MANT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  capCtrlT           ctrl,
  input  logic [ADDR_W-1:0] capAddr,
  input  logic [EXP_W-1:0]  capExp,
  input  logic [MANT_W-1:0] capMant,
  input  logic [MANT_W:0]   capFinger,
  output logic              fingerFits,
  output logic [ADDR_W-1:0] segBase,
  output logic [ADDR_W-1:0] segSize
);
  localparam int SIZE_W = ADDR_W + MANT_W + 2;

  logic [EXP_W-1:0]  blockShift;
  logic [MANT_W:0]   lastBlock;
  logic [MANT_W+1:0] blockCount;
  logic [ADDR_W-1:0] lowMask;
  logic [ADDR_W-1:0] fingerOffset;
  logic [ADDR_W-1:0] baseNext;
  logic [SIZE_W-1:0] sizeWide;
  logic [ADDR_W-1:0] sizeNext;

  capSizeDecode #(.EXP_W(EXP_W), .MANT_W(MANT_W)) decode_i (
    .expCode   (capExp),
    .mantCode  (capMant),
    .blockShift(blockShift),
    .lastBlock (lastBlock),
    .blockCount(blockCount)
  );

  always_comb begin
    lowMask      = (ADDR_W'(1) << blockShift) - ADDR_W'(1);
    fingerOffset = (capAddr & lowMask) | (ADDR_W'(capFinger) << blockShift);
    baseNext     = capAddr - fingerOffset;
    sizeWide     = SIZE_W'(blockCount) << blockShift;
    sizeNext     = (|sizeWide[SIZE_W-1:ADDR_W]) ? '1 : sizeWide[ADDR_W-1:0];
    fingerFits   = capFinger <= lastBlock;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      segBase <= '0;
      segSize <= '0;
    end else if (ctrl.capture) begin
      segBase <= ctrl.accept ? baseNext : '0;
      segSize <= ctrl.accept ? sizeNext : '0;
    end
  end
endmodule

// File: rtl/capBaseCtrl.sv
module capBaseCtrl
  import capBasePkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqStrobe,
  input  logic    capTag,
  input  logic    fingerFits,
  output capCtrlT ctrl,
  output logic    resValid,
  output logic    resOk
);
  always_comb begin
    ctrl.capture = reqStrobe;
    ctrl.accept  = capTag & fingerFits;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resOk    <= 1'b0;
    end else begin
      resValid <= reqStrobe;
      if (reqStrobe) resOk <= ctrl.accept;
    end
  end
endmodule

// File: rtl/capSegBase.sv
module capSegBase
  import capBasePkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int EXP_W  = 6,
  parameter int MANT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqStrobe,
  input  logic              capTag,
  input  logic [ADDR_W-1:0] capAddr,
  input  logic [EXP_W-1:0]  capExp,
  input  logic [MANT_W-1:0] capMant,
  input  logic [MANT_W:0]   capFinger,
  output logic              resValid,
  output logic              resOk,
  output logic [ADDR_W-1:0] segBase,
  output logic [ADDR_W-1:0] segSize
);
  capCtrlT ctrl;
  logic    fingerFits;

  capBaseCtrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .reqStrobe (reqStrobe),
    .capTag    (capTag),
    .fingerFits(fingerFits),
    .ctrl      (ctrl),
    .resValid  (resValid),
    .resOk     (resOk)
  );

  capBaseDatapath #(.ADDR_W(ADDR_W), .EXP_W(EXP_W), .MANT_W(MANT_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .capAddr   (capAddr),
    .capExp    (capExp),
    .capMant   (capMant),
    .capFinger (capFinger),
    .fingerFits(fingerFits),
    .segBase   (segBase),
    .segSize   (segSize)
  );
endmodule

// File: rtl/capSegBaseChk.sv
module capSegBaseChk #(
  parameter int ADDR_W = 64,
  parameter int EXP_W  = 6,
  parameter int MANT_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqStrobe,
  input logic              capTag,
  input logic [ADDR_W-1:0] capAddr,
  input logic [EXP_W-1:0]  capExp,
  input logic [MANT_W-1:0] capMant,
  input logic [MANT_W:0]   capFinger,
  input logic              resValid,
  input logic              resOk,
  input logic [ADDR_W-1:0] segBase,
  input logic [ADDR_W-1:0] segSize
);
  a_r1_strobe_follows: assert property (@(posedge clk) disable iff (!rstN)
    reqStrobe |=> resValid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !reqStrobe |=> !resValid);
  a_r2_reset_zero: assert property (@(posedge clk)
    !rstN |-> (!resValid && !resOk && segBase == '0 && segSize == '0));
  a_r3_small_size: assert property (@(posedge clk) disable iff (!rstN)
    (reqStrobe && capTag && (&capExp) && ({1'b0, capMant} >= capFinger))
      |=> (resOk && segSize == ADDR_W'($past(capMant)) + ADDR_W'(1)
           && segBase == $past(capAddr) - ADDR_W'($past(capFinger))));
  a_r6_small_reject: assert property (@(posedge clk) disable iff (!rstN)
    (reqStrobe && (&capExp) && ({1'b0, capMant} < capFinger)) |=> !resOk);
  a_r7_untagged: assert property (@(posedge clk) disable iff (!rstN)
    (reqStrobe && !capTag) |=> (!resOk && segBase == '0 && segSize == '0));
  a_r6_reject_zero: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resOk) |-> (segBase == '0 && segSize == '0));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !reqStrobe |=> ($stable(resOk) && $stable(segBase) && $stable(segSize)));
  a_r4_size_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resOk) |-> segSize != '0);
endmodule

bind capSegBase capSegBaseChk #(.ADDR_W(ADDR_W), .EXP_W(EXP_W), .MANT_W(MANT_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .reqStrobe(reqStrobe),
  .capTag   (capTag),
  .capAddr  (capAddr),
  .capExp   (capExp),
  .capMant  (capMant),
  .capFinger(capFinger),
  .resValid (resValid),
  .resOk    (resOk),
  .segBase  (segBase),
  .segSize  (segSize)
);

// File: tb/capSegBase_tb.sv
module capSegBase_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqStrobe = 1'b0;
  logic        capTag = 1'b0;
  logic [63:0] capAddr = '0;
  logic [5:0]  capExp = '0;
  logic [3:0]  capMant = '0;
  logic [4:0]  capFinger = '0;
  logic        resValid;
  logic        resOk;
  logic [63:0] segBase;
  logic [63:0] segSize;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic        expValid = 1'b0;
  logic        expOk = 1'b0;
  logic [63:0] expBase = '0;
  logic [63:0] expSize = '0;

  always #5 clk = ~clk;

  capSegBase dut_i (
    .clk(clk), .rstN(rstN), .reqStrobe(reqStrobe), .capTag(capTag),
    .capAddr(capAddr), .capExp(capExp), .capMant(capMant), .capFinger(capFinger),
    .resValid(resValid), .resOk(resOk), .segBase(segBase), .segSize(segSize)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Behavioural reference: 128-bit arithmetic on the decoded fields
  task automatic model(input logic tag, input logic [63:0] a, input logic [5:0] e,
                       input logic [3:0] m, input logic [4:0] f);
    int b;
    int lastIdx;
    logic [127:0] blk;
    logic [127:0] wide;
    if (e == 6'd63) begin b = 0; lastIdx = int'(m); end
    else begin b = int'(e); lastIdx = int'(m) + 16; end
    if (!tag || int'(f) > lastIdx) begin
      expOk = 1'b0; expBase = '0; expSize = '0;
    end else begin
      expOk = 1'b1;
      blk  = 128'd1 << b;
      wide = {64'd0, a} - ({64'd0, a} % blk) - (128'(f) * blk);
      expBase = wide[63:0];
      wide = 128'(lastIdx + 1) * blk;
      expSize = (wide[127:64] != 0) ? '1 : wide[63:0];
    end
  endtask

  task automatic step(input string req, input logic stb, input logic tag,
                      input logic [63:0] a, input logic [5:0] e,
                      input logic [3:0] m, input logic [4:0] f);
    reqStrobe = stb; capTag = tag; capAddr = a; capExp = e; capMant = m; capFinger = f;
    if (stb) model(tag, a, e, m, f);
    expValid = stb;
    @(negedge clk);
    check("R1", {req, " valid"}, 64'(resValid), 64'(expValid));
    check(req, "ok", 64'(resOk), 64'(expOk));
    check(req, "base", segBase, expBase);
    check(req, "size", segSize, expSize);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R2", "reset valid", 64'(resValid), 64'd0);
    check("R2", "reset ok", 64'(resOk), 64'd0);
    check("R2", "reset base", segBase, 64'd0);
    check("R2", "reset size", segSize, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R3 small form
    step("R3", 1, 1, 64'h1000_0007, 6'd63, 4'd10, 5'd3);
    step("R3", 1, 1, 64'h55, 6'd63, 4'd2, 5'd2);
    step("R6", 1, 1, 64'h55, 6'd63, 4'd2, 5'd3);
    // R4 / R5 large form
    step("R4", 1, 1, 64'h2000_0015, 6'd3, 4'd11, 5'd2);
    step("R5", 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 6'd7, 4'd5, 5'd21);
    step("R5", 1, 1, 64'h0000_0000_0000_0010, 6'd4, 4'd0, 5'd16);
    step("R6", 1, 1, 64'h1234, 6'd4, 4'd0, 5'd17);
    step("R7", 1, 0, 64'h2000_0015, 6'd3, 4'd11, 5'd2);
    step("R7", 1, 0, 64'h55, 6'd63, 4'd1, 5'd9);
    // R8 saturation boundary
    step("R8", 1, 1, 64'h8000_0000_0000_0000, 6'd59, 4'd0, 5'd0);
    step("R8", 1, 1, 64'h8000_0000_0000_0000, 6'd60, 4'd0, 5'd0);
    step("R8", 1, 1, 64'hC000_0000_0000_0001, 6'd62, 4'd15, 5'd31);
    // saturation and rejection together
    step("R6", 1, 1, 64'hC000_0000_0000_0001, 6'd62, 4'd0, 5'd20);
    // R9 hold with moving inputs
    step("R4", 1, 1, 64'h7777_0123, 6'd2, 4'd9, 5'd4);
    step("R9", 0, 0, 64'hAAAA, 6'd63, 4'd1, 5'd30);
    step("R9", 0, 1, 64'h0, 6'd1, 4'd3, 5'd0);
    step("R9", 0, 1, 64'h1, 6'd63, 4'd15, 5'd1);

    for (int i = 0; i < 300; i++) begin
      logic [5:0] e;
      logic [3:0] m;
      logic [4:0] f;
      logic [63:0] a;
      a = {$urandom(), $urandom()};
      e = 6'($urandom());
      if (i % 4 == 0) e = 6'd63;
      m = 4'($urandom());
      f = 5'($urandom());
      step("R5", 1'($urandom() % 4 != 0), 1'($urandom() % 8 != 0), a, e, m, f);
    end
    step("R1", 0, 0, 64'h0, 6'd0, 4'd0, 5'd0);
    finish_run();
  end
endmodule